// File: doc/BRIEF.md
# Half-Bridge Gate Sequencer with Interlock and Dead Time

This block turns the two switching commands of one inverter leg into enable signals for the leg's upper and lower power switches. The upper command is active high and the lower command is active low. Inputs that together ask for both switches, or for neither, leave both switches off. Whenever conduction passes from one switch to the other, the block keeps both switches off for a programmable number of clock cycles. An active-low shutdown input removes both enables at once, whatever the commands are.

The two commands are sampled through a two-stage synchronizer. A three-state sequencer with a single dead-time counter then picks which switch, if any, may conduct. The shutdown input is expected to be synchronous to the clock. It masks the outputs combinationally. It also resets the sequencer, so a full dead time follows every release from shutdown. Because the dead time is counted in its own logic, the two command inputs may be tied to one control signal.

Top module: `hbg_leg_sequencer`

## Requirements
- R1: `hi_cmd` asks for the upper switch when it is 1. `lo_cmd_n` asks for the lower switch when it is 0.
- R2: With `hi_cmd`=1 and `lo_cmd_n`=1, only `hs_gate` turns on. With `hi_cmd`=0 and `lo_cmd_n`=0, only `ls_gate` turns on.
- R3: While `sd_n` is 0, both outputs are 0 in the same cycle. After `sd_n` returns to 1, both outputs stay 0 for at least DEAD_CYCLES cycles.
- R4: With `hi_cmd`=1 and `lo_cmd_n`=0, which is a request for both switches, both outputs are 0.
- R5: With `hi_cmd`=0 and `lo_cmd_n`=1, which is a request for neither switch, both outputs are 0.
- R6: `hs_gate` and `ls_gate` are never 1 together. Every turn-on is preceded by at least DEAD_CYCLES cycles in which both outputs are 0.
- R7: When both command inputs change on the same clock edge, the handover still has exactly DEAD_CYCLES cycles with both outputs off.
- R8: If the new command arrives less than DEAD_CYCLES cycles after the old switch turned off, the new switch waits out the full dead time. If the gap is longer, the new switch follows its command with no added delay.
- R9: After reset both outputs are 0. With a valid request held, the first turn-on is seen exactly DEAD_CYCLES cycles after the reset is released.
- R10: A command change that turns a switch off shows at the output three clock edges after it is applied: two synchronizer stages and one sequencer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| hi_cmd | input | 1 | Upper switch command, active high |
| lo_cmd_n | input | 1 | Lower switch command, active low |
| sd_n | input | 1 | Shutdown, active low, synchronous to clk |
| hs_gate | output | 1 | Upper switch enable |
| ls_gate | output | 1 | Lower switch enable |

## Verification
The bench drives each of the four command codes and checks which of them turn a switch on and which leave the leg idle. This shows whether the mixed input polarity is decoded correctly. Handovers are tried three ways: both inputs tied to one edge, a short idle gap, and an idle gap longer than the dead time. The first two must give exactly the full dead time; the third shows whether the sequencer adds delay where none is due. A shutdown pulse applied during conduction, followed by a pseudo-random command stream, checks that both outputs drop at once and that the restart is correct.

// File: rtl/hbg_pkg.sv
// Package: shared types for the half-bridge gate sequencer.
// Assumes nothing beyond being compiled before the modules that import it.
package hbg_pkg;

    // Decoded request from the synchronized command pair
    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_HIGH = 2'd1,
        REQ_LOW  = 2'd2
    } hbg_req_e;

    // Conduction state of the leg
    typedef enum logic [1:0] {
        LEG_OFF  = 2'd0,
        LEG_HIGH = 2'd1,
        LEG_LOW  = 2'd2
    } hbg_leg_e;

endpackage

// File: rtl/hbg_sync.sv
// Module: multi-stage synchronizer for a bus of independent bits.
// Assumes: each bit is a level that stays stable for several cycles; no
// bus coherency is given. Reset loads RESET_VAL into every stage.
module hbg_sync #(
    parameter int          WIDTH     = 2,
    parameter int          STAGES    = 2,
    parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] d_out
);

    logic [STAGES-1:0][WIDTH-1:0] stage_q;

    // Stage 0 samples the asynchronous input
    always_ff @(posedge clk) begin
        if (!rst_n) stage_q[0] <= RESET_VAL;
        else        stage_q[0] <= d_in;
    end

    generate
        for (genvar s = 1; s < STAGES; s++) begin : g_stage
            // Each later stage retimes the stage before it
            always_ff @(posedge clk) begin
                if (!rst_n) stage_q[s] <= RESET_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    endgenerate

    assign d_out = stage_q[STAGES-1];

    // Each output value equals the first stage's value STAGES-1 cycles earlier
    p_chain_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (STAGES == 2) && $past(rst_n) |-> d_out == $past(stage_q[0]));

endmodule

// File: rtl/hbg_decode.sv
// Module: truth-table decode of the mixed-polarity command pair.
// Assumes synchronized inputs. The upper command is active high and the
// lower one active low. A request for both switches, or for neither,
// decodes to REQ_NONE.
module hbg_decode
    import hbg_pkg::*;
(
    input  logic     hi_req,
    input  logic     lo_req_n,
    output hbg_req_e req
);

    // Combinational decode of the four input codes
    always_comb begin
        unique case ({hi_req, lo_req_n})
            2'b11:   req = REQ_HIGH;   // upper asked, lower idle
            2'b00:   req = REQ_LOW;    // lower asked, upper idle
            default: req = REQ_NONE;   // conflict or idle
        endcase
    end

endmodule

// File: rtl/hbg_deadtime.sv
// Module: leg sequencer with dead-time counter.
// Assumes req is synchronous and sd_n is synchronous to clk. A single
// counter, loaded whenever conduction ends or shutdown/reset is seen,
// must reach zero before either switch may turn on. DEAD_CYCLES >= 1.
module hbg_deadtime
    import hbg_pkg::*;
#(
    parameter int DEAD_CYCLES = 50
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     sd_n,
    input  hbg_req_e req,
    output logic     hs_on,
    output logic     ls_on
);

    localparam int CNT_W = (DEAD_CYCLES < 2) ? 1 : $clog2(DEAD_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD  = CNT_W'(DEAD_CYCLES - 1);
    localparam logic [CNT_W-1:0] GAP_MAX = CNT_W'(DEAD_CYCLES);

    hbg_leg_e         state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // Next-state and counter decision
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (!sd_n) begin
            state_d = LEG_OFF;
            cnt_d   = RELOAD;
        end else begin
            unique case (state_q)
                LEG_OFF: begin
                    if (cnt_q != '0) begin
                        cnt_d = cnt_q - 1'b1;
                    end else if (req == REQ_HIGH) begin
                        state_d = LEG_HIGH;
                    end else if (req == REQ_LOW) begin
                        state_d = LEG_LOW;
                    end
                end
                LEG_HIGH: begin
                    if (req != REQ_HIGH) begin
                        state_d = LEG_OFF;
                        cnt_d   = RELOAD;
                    end
                end
                LEG_LOW: begin
                    if (req != REQ_LOW) begin
                        state_d = LEG_OFF;
                        cnt_d   = RELOAD;
                    end
                end
                default: begin
                    state_d = LEG_OFF;
                    cnt_d   = RELOAD;
                end
            endcase
        end
    end

    // State and counter registers, reset to off with a full dead time pending
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= LEG_OFF;
            cnt_q   <= RELOAD;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    assign hs_on = (state_q == LEG_HIGH);
    assign ls_on = (state_q == LEG_LOW);

    // Checker support: cycles spent with both switches off, saturating
    logic [CNT_W-1:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                gap_q <= '0;
        else if (hs_on || ls_on)   gap_q <= '0;
        else if (gap_q != GAP_MAX) gap_q <= gap_q + 1'b1;
    end

    p_sd_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_n |=> (state_q == LEG_OFF));

    p_conflict_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req == REQ_NONE) |=> (state_q == LEG_OFF));

    p_gap_hs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hs_on) |-> (gap_q >= GAP_MAX));

    p_gap_ls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ls_on) |-> (gap_q >= GAP_MAX));

    p_direct_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LEG_OFF && cnt_q == '0 && req == REQ_LOW && sd_n) |=> ls_on);

    p_direct_high_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LEG_OFF && cnt_q == '0 && req == REQ_HIGH && sd_n) |=> hs_on);

    p_hold_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_on && req == REQ_HIGH && sd_n) |=> hs_on);

endmodule

// File: rtl/hbg_leg_sequencer.sv
// Module: top of the half-bridge gate sequencer for one inverter leg.
// Assumes: hi_cmd/lo_cmd_n are asynchronous levels; sd_n is synchronous
// to clk and masks the outputs in the cycle it is low. Dead time is
// DEAD_CYCLES clock cycles (50 cycles = 200 ns at 250 MHz).
module hbg_leg_sequencer
    import hbg_pkg::*;
#(
    parameter int DEAD_CYCLES = 50,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hi_cmd,
    input  logic lo_cmd_n,
    input  logic sd_n,
    output logic hs_gate,
    output logic ls_gate
);

    localparam int CMD_W = 2;
    // Idle code for the command pair: upper off, lower (active low) off
    localparam logic [CMD_W-1:0] CMD_IDLE = 2'b01;

    logic [CMD_W-1:0] cmd_sync;
    hbg_req_e         req;
    logic             hs_on, ls_on;

    hbg_sync #(
        .WIDTH     (CMD_W),
        .STAGES    (SYNC_STAGES),
        .RESET_VAL (CMD_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({hi_cmd, lo_cmd_n}),
        .d_out (cmd_sync)
    );

    hbg_decode u_decode (
        .hi_req   (cmd_sync[1]),
        .lo_req_n (cmd_sync[0]),
        .req      (req)
    );

    hbg_deadtime #(
        .DEAD_CYCLES (DEAD_CYCLES)
    ) u_dead (
        .clk   (clk),
        .rst_n (rst_n),
        .sd_n  (sd_n),
        .req   (req),
        .hs_on (hs_on),
        .ls_on (ls_on)
    );

    // Shutdown masks both enables without waiting for a clock edge
    always_comb begin
        hs_gate = hs_on & sd_n;
        ls_gate = ls_on & sd_n;
    end

    p_one_side_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_gate && ls_gate));

    p_sd_now_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_n |-> !hs_gate && !ls_gate);

endmodule

// File: tb/tb_hbg_leg_sequencer.sv
module tb_hbg_leg_sequencer;

    localparam int D = 50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hi_cmd = 1'b0;
    logic lo_cmd_n = 1'b1;
    logic sd_n = 1'b1;
    logic hs_gate, ls_gate;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string phase = "R9";

    always #2 clk = ~clk; // 250 MHz

    hbg_leg_sequencer #(.DEAD_CYCLES(D)) dut (
        .clk(clk), .rst_n(rst_n), .hi_cmd(hi_cmd), .lo_cmd_n(lo_cmd_n),
        .sd_n(sd_n), .hs_gate(hs_gate), .ls_gate(ls_gate)
    );

    // Behavioural reference: 2-deep command delay line, leg mode, dead counter
    int m_mode = 0;      // 0 idle, 1 upper, 2 lower
    int m_cnt  = D - 1;
    bit q_h[$] = '{0, 0};
    bit q_l[$] = '{1, 1};

    always @(posedge clk) begin
        int want;
        if (!rst_n) begin
            m_mode = 0; m_cnt = D - 1;
            q_h = '{0, 0}; q_l = '{1, 1};
        end else begin
            if (q_h[0] && q_l[0])        want = 1;
            else if (!q_h[0] && !q_l[0]) want = 2;
            else                         want = 0;
            if (!sd_n) begin
                m_mode = 0; m_cnt = D - 1;
            end else if (m_mode == 0) begin
                if (m_cnt > 0) m_cnt--;
                else           m_mode = want;
            end else if (m_mode != want) begin
                m_mode = 0; m_cnt = D - 1;
            end
            void'(q_h.pop_front()); void'(q_l.pop_front());
            q_h.push_back(hi_cmd); q_l.push_back(lo_cmd_n);
        end
    end

    task automatic check(string req, logic act, logic exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, plus an independent gap check (R6)
    int gap = 0;
    logic prev_hs = 0, prev_ls = 0;
    always @(posedge clk) begin
        #3;
        if (rst_n && !done) begin
            check(phase, hs_gate, (m_mode == 1) && sd_n, "hs_gate vs model");
            check(phase, ls_gate, (m_mode == 2) && sd_n, "ls_gate vs model");
            if (hs_gate && ls_gate) check("R6", 1'b1, 1'b0, "both gates on");
            if ((hs_gate && !prev_hs) || (ls_gate && !prev_ls)) begin
                checks++;
                if (gap < D) begin
                    errors++;
                    $display("FAIL R6 dead gap: actual %0d expected >= %0d", gap, D);
                end
            end
        end
        gap = (hs_gate || ls_gate) ? 0 : gap + 1;
        prev_hs = hs_gate; prev_ls = ls_gate;
    end

    task automatic tick(int n = 1);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic look();
        #1;
    endtask

    // Counts ticks until a gate is 1, bounded
    task automatic ticks_until(bit upper, output int n);
        n = 0;
        forever begin
            tick(); look(); n++;
            if ((upper ? hs_gate : ls_gate) || n > 4 * D) break;
        end
    endtask

    initial begin
        int n;
        // R9: reset state, then first turn-on after exactly D cycles
        phase = "R9";
        hi_cmd = 1; lo_cmd_n = 1;
        tick(5); look();
        check("R9", hs_gate, 1'b0, "hs in reset");
        check("R9", ls_gate, 1'b0, "ls in reset");
        rst_n = 1;
        ticks_until(1, n);
        checks++;
        if (n != D) begin errors++; $display("FAIL R9 first turn-on: actual %0d expected %0d", n, D); end

        // R2 / R1: upper held on
        phase = "R2";
        tick(20); look();
        check("R2", hs_gate, 1'b1, "upper only, hs");
        check("R1", ls_gate, 1'b0, "upper only, ls");

        // R7 / R10: both inputs switch on the same edge
        phase = "R7";
        hi_cmd = 0; lo_cmd_n = 0;
        tick(2); look();
        check("R10", hs_gate, 1'b1, "hs still on after 2 edges");
        tick(); look();
        check("R10", hs_gate, 1'b0, "hs off after 3 edges");
        ticks_until(0, n);
        checks++;
        if (n != D) begin errors++; $display("FAIL R7 tied handover gap: actual %0d expected %0d", n, D); end
        check("R2", ls_gate, 1'b1, "lower only, ls");

        // R4: conflict code, both asked
        phase = "R4";
        hi_cmd = 1; lo_cmd_n = 0;
        tick(3 + 2 * D); look();
        check("R4", hs_gate, 1'b0, "conflict hs");
        check("R4", ls_gate, 1'b0, "conflict ls");

        // R5: idle code
        phase = "R5";
        hi_cmd = 0; lo_cmd_n = 1;
        tick(D); look();
        check("R5", hs_gate, 1'b0, "idle hs");
        check("R5", ls_gate, 1'b0, "idle ls");

        // R8 long gap: idle long enough, lower follows in 3 edges
        phase = "R8";
        lo_cmd_n = 0;
        tick(2); look();
        check("R8", ls_gate, 1'b0, "lower not yet");
        tick(); look();
        check("R8", ls_gate, 1'b1, "direct follow");

        // R8 short gap: release lower, ask upper 5 cycles later
        lo_cmd_n = 1;
        tick(5);
        hi_cmd = 1;
        ticks_until(1, n);
        checks++;
        if (n != D + 3 - 5) begin
            errors++; $display("FAIL R8 short gap wait: actual %0d expected %0d", n, D - 2);
        end

        // R3: shutdown during conduction
        phase = "R3";
        tick(10);
        sd_n = 0; look();
        check("R3", hs_gate, 1'b0, "shutdown same cycle hs");
        check("R3", ls_gate, 1'b0, "shutdown same cycle ls");
        tick(4);
        sd_n = 1;
        ticks_until(1, n);
        checks++;
        if (n != D) begin errors++; $display("FAIL R3 restart delay: actual %0d expected %0d", n, D); end

        // Mixed stream compared each cycle against the model
        phase = "R6";
        for (int i = 0; i < 300; i++) begin
            int r = $urandom_range(0, 99);
            if (r < 30)      begin hi_cmd = 1; lo_cmd_n = 1; end
            else if (r < 60) begin hi_cmd = 0; lo_cmd_n = 0; end
            else if (r < 75) begin hi_cmd = 1; lo_cmd_n = 0; end
            else if (r < 90) begin hi_cmd = 0; lo_cmd_n = 1; end
            sd_n = ($urandom_range(0, 49) != 0);
            tick($urandom_range(1, 2 * D));
        end
        sd_n = 1;
        tick(5);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule